// File: doc/BRIEF.md
# Pivot Rotation Offset Generator

This block turns one placement command into the signed column and row offsets for a single cell of a rectangular processing grid. The grid is numbered column by column, so a linear cell address splits into a column (the address divided by the grid height) and a row (the remainder). A downstream instruction rewriter adds the two offsets to the cell's coordinates to find where that cell's configuration must go.

Each command has two modes. In shift mode the two coordinate inputs are themselves the offsets and pass straight through. In turn mode the coordinate inputs name a pivot cell, and the block computes the offset that carries the addressed cell a quarter turn about the pivot, either clockwise or anticlockwise. A controller walks the cells of an application through the block one address per cycle. Each result appears one clock after its command, together with a valid flag.

Top module: `pivot_offset_gen`

## Requirements
- R1: With `turn_en` = 0, a command yields `dx_out` = `pivot_x` and `dy_out` = `pivot_y` unchanged, whatever `cell_addr` and `cw_en` hold.
- R2: With `turn_en` = 1 and `cw_en` = 0 (anticlockwise), let a = column − `pivot_x` and b = row − `pivot_y`. The cell moves to relative position (b, −a), so `dx_out` = b − a and `dy_out` = −(a + b). On a 3×4 grid (height 4) with pivot (0,2), address 7 gives (0,−2) and address 10 gives (−2,−2).
- R3: With `turn_en` = 1 and `cw_en` = 1 (clockwise), the cell moves to relative position (−b, a), so `dx_out` = −(a + b) and `dy_out` = a − b.
- R4: The column is `cell_addr` / GRID_H and the row is `cell_addr` % GRID_H. This holds both when GRID_H is a power of two and when it is not.
- R5: In turn mode, an address equal to the pivot cell yields `dx_out` = `dy_out` = 0 in either direction.
- R6: A command presented with `cmd_valid` = 1 at a rising clock edge produces `res_valid` = 1 and its offsets after that edge. `res_valid` falls after an edge at which `cmd_valid` is 0.
- R7: While reset is asserted, `res_valid` is 0 and both offsets are 0.
- R8: When `cmd_valid` is 0, the input values have no effect: `dx_out` and `dy_out` keep their previous values.
- R9: The offsets are two's-complement values wide enough to hold every result the grid can produce. For the default 3×4 grid they are 4 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| turn_en | input | 1 | 1 selects turn mode, 0 selects shift mode |
| cw_en | input | 1 | In turn mode, 1 selects clockwise and 0 anticlockwise |
| pivot_x | input | OFS_W | Column offset (shift) or pivot column (turn), two's complement |
| pivot_y | input | OFS_W | Row offset (shift) or pivot row (turn), two's complement |
| cell_addr | input | ADDR_W | Linear column-major address of the cell being moved |
| res_valid | output | 1 | Offsets below belong to a command taken at the last edge |
| dx_out | output | OFS_W | Signed column offset |
| dy_out | output | OFS_W | Signed row offset |

## Verification
Every result of this block is due exactly one rising edge after its command, because the only register lies between the offset arithmetic and the ports. The bench drives each command on a falling edge and reads `res_valid`, `dx_out` and `dy_out` at the next falling edge, half a period after the capturing edge. The hold behaviour is checked one and two cycles after `cmd_valid` drops, and the reset values are checked while reset is still low. Two copies of the block run side by side, one with a height of 4 and one with a height of 3, so that the results of both the shift-and-mask split and the divider split are compared against the bench's own model.

// File: rtl/pivot_offset_pkg.sv
package pivot_offset_pkg;

   typedef enum logic [1:0] {
      XF_SHIFT = 2'd0,
      XF_ACW   = 2'd1,
      XF_CW    = 2'd2
   } xform_e;

   function automatic int clog2_min1(input int v);
      int r;
      r = 1;
      while ((1 << r) < v) r++;
      return r;
   endfunction

   // Largest magnitude of any offset is 2*(max dimension - 1); one sign bit on top.
   function automatic int offset_width(input int w, input int h);
      int mx;
      mx = ((w > h) ? w : h) - 1;
      return clog2_min1(2 * mx + 1) + 1;
   endfunction

   function automatic xform_e pick_xform(input logic turn, input logic cw);
      if (!turn)   return XF_SHIFT;
      else if (cw) return XF_CW;
      else         return XF_ACW;
   endfunction

endpackage

// File: rtl/pivot_addr_split.sv
module pivot_addr_split #(
   parameter int GRID_H = 4,
   parameter int ADDR_W = 4,
   parameter int COL_W  = 2,
   parameter int ROW_W  = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [COL_W-1:0]  col,
   output logic [ROW_W-1:0]  row
);
   localparam logic [ADDR_W-1:0] H_A     = ADDR_W'(GRID_H);
   localparam bit                H_POW2  = ((GRID_H & (GRID_H - 1)) == 0);

   logic [ADDR_W-1:0] quo;
   logic [ADDR_W-1:0] rem;

   generate
      if (H_POW2) begin : g_shift
         always_comb begin
            quo = addr >> ROW_W;
            rem = addr & (H_A - ADDR_W'(1));
         end
      end else begin : g_divide
         always_comb begin
            quo = addr / H_A;
            rem = addr % H_A;
         end
      end
   endgenerate

   assign col = quo[COL_W-1:0];
   assign row = rem[ROW_W-1:0];

   always_comb begin
      assert_row_in_range_R4: assert (rem < H_A)
         else $error("row remainder out of range");
   end

endmodule

// File: rtl/pivot_turn_calc.sv
module pivot_turn_calc
   import pivot_offset_pkg::*;
#(
   parameter int COL_W = 2,
   parameter int ROW_W = 2,
   parameter int OFS_W = 4
) (
   input  xform_e                  mode,
   input  logic        [COL_W-1:0] col,
   input  logic        [ROW_W-1:0] row,
   input  logic signed [OFS_W-1:0] px,
   input  logic signed [OFS_W-1:0] py,
   output logic signed [OFS_W-1:0] dx,
   output logic signed [OFS_W-1:0] dy
);
   logic signed [OFS_W-1:0] col_s, row_s, rel_a, rel_b, sum_ab;

   always_comb begin
      col_s  = signed'({{(OFS_W-COL_W){1'b0}}, col});
      row_s  = signed'({{(OFS_W-ROW_W){1'b0}}, row});
      rel_a  = col_s - px;
      rel_b  = row_s - py;
      sum_ab = rel_a + rel_b;
      unique case (mode)
         XF_ACW: begin
            dx = rel_b - rel_a;
            dy = -sum_ab;
         end
         XF_CW: begin
            dx = -sum_ab;
            dy = rel_a - rel_b;
         end
         default: begin
            dx = px;
            dy = py;
         end
      endcase
   end

endmodule

// File: rtl/pivot_offset_gen.sv
module pivot_offset_gen
   import pivot_offset_pkg::*;
#(
   parameter  int GRID_W = 3,
   parameter  int GRID_H = 4,
   localparam int ADDR_W = clog2_min1(GRID_W * GRID_H),
   localparam int OFS_W  = offset_width(GRID_W, GRID_H)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_valid,
   input  logic                    turn_en,
   input  logic                    cw_en,
   input  logic signed [OFS_W-1:0] pivot_x,
   input  logic signed [OFS_W-1:0] pivot_y,
   input  logic       [ADDR_W-1:0] cell_addr,
   output logic                    res_valid,
   output logic signed [OFS_W-1:0] dx_out,
   output logic signed [OFS_W-1:0] dy_out
);
   localparam int COL_W = clog2_min1(GRID_W);
   localparam int ROW_W = clog2_min1(GRID_H);

   initial begin
      assert_grid_h_R4: assert (GRID_H >= 2) else $error("GRID_H must be at least 2");
      assert_grid_w_R4: assert (GRID_W >= 2) else $error("GRID_W must be at least 2");
      assert_width_R9:  assert (OFS_W > COL_W && OFS_W > ROW_W)
         else $error("offset width too small");
   end

   logic [COL_W-1:0]        cell_col;
   logic [ROW_W-1:0]        cell_row;
   logic signed [OFS_W-1:0] dx_next, dy_next;
   xform_e                  mode;

   assign mode = pick_xform(turn_en, cw_en);

   pivot_addr_split #(
      .GRID_H (GRID_H),
      .ADDR_W (ADDR_W),
      .COL_W  (COL_W),
      .ROW_W  (ROW_W)
   ) u_split (
      .addr (cell_addr),
      .col  (cell_col),
      .row  (cell_row)
   );

   pivot_turn_calc #(
      .COL_W (COL_W),
      .ROW_W (ROW_W),
      .OFS_W (OFS_W)
   ) u_calc (
      .mode (mode),
      .col  (cell_col),
      .row  (cell_row),
      .px   (pivot_x),
      .py   (pivot_y),
      .dx   (dx_next),
      .dy   (dy_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         dx_out    <= '0;
         dy_out    <= '0;
      end else begin
         res_valid <= cmd_valid;
         if (cmd_valid) begin
            dx_out <= dx_next;
            dy_out <= dy_next;
         end
      end
   end

   // Pivot detection from the split outputs, independent of the arithmetic path.
   logic pivot_hit;
   assign pivot_hit = (signed'({{(OFS_W-COL_W){1'b0}}, cell_col}) == pivot_x) &&
                      (signed'({{(OFS_W-ROW_W){1'b0}}, cell_row}) == pivot_y);

   assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> res_valid);
   assert_valid_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !res_valid);
   assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> ($stable(dx_out) && $stable(dy_out)));
   assert_shift_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !turn_en) |=> (dx_out == $past(pivot_x) && dy_out == $past(pivot_y)));
   assert_pivot_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && turn_en && pivot_hit) |=> (dx_out == '0 && dy_out == '0));

endmodule

// File: tb/pivot_offset_gen_tb.sv
`timescale 1ns/1ps
module pivot_offset_gen_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0, turn_en = 1'b0, cw_en = 1'b0;
   logic signed [3:0] pivot_x = '0, pivot_y = '0;
   logic [3:0] cell_addr = '0;
   logic res_valid, res_valid3;
   logic signed [3:0] dx_out, dy_out, dx3, dy3;
   int n_checks = 0, n_fail = 0, cycles = 0;

   always #2.5 clk = ~clk;

   pivot_offset_gen #(.GRID_W(3), .GRID_H(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .turn_en(turn_en), .cw_en(cw_en),
      .pivot_x(pivot_x), .pivot_y(pivot_y), .cell_addr(cell_addr),
      .res_valid(res_valid), .dx_out(dx_out), .dy_out(dy_out));

   pivot_offset_gen #(.GRID_W(4), .GRID_H(3)) u_dut3 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .turn_en(turn_en), .cw_en(cw_en),
      .pivot_x(pivot_x), .pivot_y(pivot_y), .cell_addr(cell_addr),
      .res_valid(res_valid3), .dx_out(dx3), .dy_out(dy3));

   // stimulus: turn, cw, x, y, addr
   localparam int NV = 12;
   localparam int VEC [NV][5] = '{
      '{0, 0,  2, -1,  5}, '{0, 1, -3,  3,  0}, '{0, 0,  0,  0, 11},
      '{1, 0,  0,  2,  7}, '{1, 0,  0,  2, 10}, '{1, 1,  0,  2,  7},
      '{1, 1,  1,  1,  4}, '{1, 0,  1,  1,  9}, '{1, 1,  2,  0, 11},
      '{1, 0,  1,  2,  6}, '{1, 1,  0,  0,  0}, '{1, 0,  2,  1,  8}};

   task automatic check(input string tag, input int act_x, input int act_y,
                        input int exp_x, input int exp_y);
      n_checks++;
      if (act_x != exp_x || act_y != exp_y) begin
         n_fail++;
         $display("FAIL %s: actual (%0d,%0d) expected (%0d,%0d)", tag, act_x, act_y, exp_x, exp_y);
      end
   endtask

   task automatic model(input int t, input int c, input int x, input int y, input int addr,
                        input int h, output int ex, output int ey);
      int a, b;
      a = addr / h - x;
      b = addr % h - y;
      if (t == 0)      begin ex = x;        ey = y;        end
      else if (c == 0) begin ex = b - a;    ey = -(a + b); end
      else             begin ex = -(a + b); ey = a - b;    end
   endtask

   task automatic issue(input int t, input int c, input int x, input int y, input int addr);
      @(negedge clk);
      cmd_valid = 1'b1; turn_en = t[0]; cw_en = c[0];
      pivot_x = 4'(x); pivot_y = 4'(y); cell_addr = 4'(addr);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 5000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 5000", cycles);
            finish_run();
         end
      end
   end

   initial begin
      int ex, ey;
      repeat (3) @(negedge clk);
      // R7: reset state while reset held, even with a command present
      cmd_valid = 1'b1; turn_en = 1'b0; pivot_x = 4'sd3; pivot_y = 4'sd2;
      @(negedge clk);
      check("R7 reset h4", int'(res_valid), int'(dx_out) + int'(dy_out), 0, 0);
      check("R7 reset h3", int'(res_valid3), int'(dx3) + int'(dy3), 0, 0);
      cmd_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table: both heights against the model
      for (int i = 0; i < NV; i++) begin
         string tg;
         tg = (VEC[i][0] == 0) ? "R1" : ((VEC[i][1] == 0) ? "R2" : "R3");
         issue(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
         model(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 4, ex, ey);
         check($sformatf("%s h4 vec%0d", tg, i), int'(dx_out), int'(dy_out), ex, ey);
         model(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 3, ex, ey);
         check($sformatf("%s R4 h3 vec%0d", tg, i), int'(dx3), int'(dy3), ex, ey);
      end

      // R2: worked example with literal values
      issue(1, 0, 0, 2, 7);
      check("R2 addr7 literal", int'(dx_out), int'(dy_out), 0, -2);
      issue(1, 0, 0, 2, 10);
      check("R2 addr10 literal", int'(dx_out), int'(dy_out), -2, -2);

      // R4: non-power-of-two split, addr 7 on height 3 is column 2 row 1
      issue(1, 1, 2, 1, 7);
      check("R4 h3 addr7 is pivot", int'(dx3), int'(dy3), 0, 0);

      // R5: pivot cell itself, both directions
      issue(1, 0, 1, 1, 5);
      check("R5 acw h4 pivot", int'(dx_out), int'(dy_out), 0, 0);
      issue(1, 1, 1, 1, 4);
      check("R5 cw h3 pivot", int'(dx3), int'(dy3), 0, 0);

      // R6: valid timing
      issue(0, 0, 1, 1, 0);
      check("R6 valid one cycle after", int'(res_valid), int'(res_valid3), 1, 1);
      @(negedge clk);
      check("R6 valid drops", int'(res_valid), int'(res_valid3), 0, 0);

      // R8: idle inputs change nothing
      issue(1, 1, 0, 0, 11);
      model(1, 1, 0, 0, 11, 4, ex, ey);
      check("R3 h4 before idle", int'(dx_out), int'(dy_out), ex, ey);
      turn_en = 1'b0; pivot_x = -4'sd5; pivot_y = 4'sd6; cell_addr = 4'd3;
      @(negedge clk);
      check("R8 hold 1", int'(dx_out), int'(dy_out), ex, ey);
      @(negedge clk);
      check("R8 hold 2", int'(dx_out), int'(dy_out), ex, ey);

      // R9: widest offset on a 3x4 grid: shift of -6 fits in 4 bits
      issue(0, 0, -6, 6, 0);
      check("R9 width extremes", int'(dx_out), int'(dy_out), -6, 6);

      finish_run();
   end
endmodule